// File: doc/BRIEF.md
# Flash Page-Mode Configuration Command Decoder

This block sits in the command interface of a parallel NOR-style flash device. It watches bus write cycles, classifies the byte on the data lines as a command, and keeps track of what a read returns next: array data, the status register or identifier/register data. It also holds a small volatile configuration register whose single live bit picks the length of asynchronous page reads, either four words or eight words.

The configuration value does not travel on the data bus. It rides on the low sixteen address lines of a setup write (command 0x60). A confirm write (0x04) must repeat the same value. Choosing four-word pages takes effect at the confirm. Choosing eight-word pages is only held as a pending request until a clear-status write (0x50) arrives. The read path uses the page-word mask output to decide which low word-address bits count as offsets inside a page. In register-access mode that mask is zero, so only one word is fetched.

All state updates on the rising clock edge at which `we_i` is sampled high, so outputs show the effect of a write one clock later. The active-low reset pin returns everything to its defaults at once.

Top module: `flcfg_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no write, `mode_o` is 2'b00 (array), `cfg_o` is 0, `page8_o` is 0, `err_o` is 0 and `mask_o` is 3'b011.
- R2: With no setup pending, a write of 0xFF sets `mode_o` to 2'b00 (array), 0x70 sets it to 2'b01 (status) and 0x90 sets it to 2'b10 (register access). The new mode shows in the cycle after the write.
- R3: A write of 0x60 carrying a value V on `addr_i[15:0]` is a setup write. If the next write carries 0x04 with the same V on `addr_i[15:0]`, V is accepted and `mode_o` becomes 2'b00. `addr_i[23:16]` plays no part in the comparison.
- R4: Bit 13 of the register (`cfg_o[13]`, mirrored on `page8_o`) set to 1 selects eight-word pages, and 0 selects four-word pages. An accepted V with bit 13 set changes nothing visible until the next write, and only if that write is 0x50 (any address). That write then sets `page8_o` and `cfg_o[13]` to 1.
- R5: Bits [15:14] and [12:0] of `cfg_o` always read 0, whatever V carried.
- R6: If the write after a setup does not carry 0x04, or carries a different V, the register is left unchanged, `mode_o` becomes 2'b01 and `err_o` becomes 1. A later 0x50 write clears `err_o`.
- R7: If any write other than 0x50 follows an accepted eight-word request, the request is dropped and `page8_o` stays 0.
- R8: `mask_o` is 3'b011 in four-word mode and 3'b111 in eight-word mode, and 3'b000 whenever `mode_o` is 2'b10.
- R9: A cycle with `we_i` low changes none of the outputs.
- R10: An accepted V with bit 13 clear returns the block to four-word pages (`page8_o` 0) in the cycle after the confirm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset pin |
| we_i | input | 1 | Write strobe, one sampled write per high cycle |
| addr_i | input | 24 | Bus address; bits [15:0] carry the configuration value |
| data_i | input | 8 | Command byte |
| mode_o | output | 2 | Read mode: 00 array, 01 status, 10 register access |
| page8_o | output | 1 | 1 when eight-word pages are in effect |
| mask_o | output | 3 | Word-address bits treated as intra-page offset |
| cfg_o | output | 16 | Configuration register read-back |
| err_o | output | 1 | Set by a failed configuration sequence |

## Verification
The block's internal state shows at the ports in one of three ways. A stuck or lost setup state shows in `mode_o` and `err_o` one clock after the confirm write, as a spurious error or as a missing return to array mode. A mishandled pending eight-word request shows only one write later, in `page8_o` and `mask_o` right after the following 0x50 or other command. The bench therefore checks every output after every write and after idle cycles. A corrupted reserved bit is visible at once on `cfg_o`.

// File: rtl/flcfg_pkg.sv
package flcfg_pkg;
   typedef enum logic [1:0] {
      RD_ARRAY  = 2'b00,
      RD_STATUS = 2'b01,
      RD_REG    = 2'b10
   } rd_mode_e;

   typedef enum logic [2:0] {
      OP_ARRAY,
      OP_STATUS,
      OP_REG,
      OP_CLEAR,
      OP_SETUP,
      OP_OTHER
   } op_e;

   localparam logic [7:0] CMD_ARRAY   = 8'hFF;
   localparam logic [7:0] CMD_STATUS  = 8'h70;
   localparam logic [7:0] CMD_REG     = 8'h90;
   localparam logic [7:0] CMD_CLEAR   = 8'h50;
   localparam logic [7:0] CMD_SETUP   = 8'h60;
   localparam logic [7:0] CMD_CONFIRM = 8'h04;
endpackage

// File: rtl/flcfg_decode.sv
module flcfg_decode
   import flcfg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output op_e               op_o
);
   logic [7:0] cmd;
   assign cmd = data_i[7:0];

   always_comb begin
      unique case (cmd)
         CMD_ARRAY:  op_o = OP_ARRAY;
         CMD_STATUS: op_o = OP_STATUS;
         CMD_REG:    op_o = OP_REG;
         CMD_CLEAR:  op_o = OP_CLEAR;
         CMD_SETUP:  op_o = OP_SETUP;
         default:    op_o = OP_OTHER;
      endcase
   end
endmodule

// File: rtl/flcfg_seq.sv
module flcfg_seq
   import flcfg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int VAL_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  op_e               op_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [VAL_W-1:0]  val_i,
   output rd_mode_e          mode_o,
   output logic              err_o,
   output logic              accept_o,
   output logic [VAL_W-1:0]  held_o,
   output logic              clear_o
);
   logic             armed_q;
   logic [VAL_W-1:0] held_q;
   rd_mode_e         mode_q;
   logic             err_q;
   logic             match;

   assign match    = (data_i[7:0] == CMD_CONFIRM) && (val_i == held_q);
   assign accept_o = we_i && armed_q && match;
   assign clear_o  = we_i && !armed_q && (op_i == OP_CLEAR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         held_q  <= '0;
         mode_q  <= RD_ARRAY;
         err_q   <= 1'b0;
      end else if (we_i) begin
         if (armed_q) begin
            armed_q <= 1'b0;
            if (match) begin
               mode_q <= RD_ARRAY;
            end else begin
               mode_q <= RD_STATUS;
               err_q  <= 1'b1;
            end
         end else begin
            unique case (op_i)
               OP_ARRAY:  mode_q <= RD_ARRAY;
               OP_STATUS: mode_q <= RD_STATUS;
               OP_REG:    mode_q <= RD_REG;
               OP_CLEAR:  err_q  <= 1'b0;
               OP_SETUP: begin
                  armed_q <= 1'b1;
                  held_q  <= val_i;
               end
               default: ;
            endcase
         end
      end
   end

   assign mode_o = mode_q;
   assign err_o  = err_q;
   assign held_o = held_q;
endmodule

// File: rtl/flcfg_store.sv
module flcfg_store #(
   parameter int VAL_W    = 16,
   parameter int PAGE_BIT = 13
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic             accept_i,
   input  logic             clear_i,
   input  logic [VAL_W-1:0] held_i,
   output logic             page8_o,
   output logic [VAL_W-1:0] cfg_o
);
   logic page_q;
   logic pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         page_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (accept_i) begin
         if (held_i[PAGE_BIT]) begin
            pend_q <= 1'b1;
         end else begin
            page_q <= 1'b0;
            pend_q <= 1'b0;
         end
      end else if (clear_i) begin
         if (pend_q) page_q <= 1'b1;
         pend_q <= 1'b0;
      end else if (we_i) begin
         pend_q <= 1'b0;
      end
   end

   for (genvar b = 0; b < VAL_W; b++) begin : g_cfg
      if (b == PAGE_BIT) begin : g_live
         assign cfg_o[b] = page_q;
      end else begin : g_rsvd
         assign cfg_o[b] = 1'b0;
      end
   end

   assign page8_o = page_q;
endmodule

// File: rtl/flcfg_mask.sv
module flcfg_mask
   import flcfg_pkg::*;
#(
   parameter int MASK_W = 3
) (
   input  rd_mode_e          mode_i,
   input  logic              page8_i,
   output logic [MASK_W-1:0] mask_o
);
   localparam int SHORT_W = MASK_W - 1;

   logic open_q;
   assign open_q = (mode_i != RD_REG);

   for (genvar b = 0; b < MASK_W; b++) begin : g_bit
      if (b < SHORT_W) begin : g_always
         assign mask_o[b] = open_q;
      end else begin : g_long
         assign mask_o[b] = open_q && page8_i;
      end
   end
endmodule

// File: rtl/flcfg_top.sv
module flcfg_top
   import flcfg_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int VAL_W    = 16,
   parameter int PAGE_BIT = 13,
   parameter int MASK_W   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [1:0]        mode_o,
   output logic              page8_o,
   output logic [MASK_W-1:0] mask_o,
   output logic [VAL_W-1:0]  cfg_o,
   output logic              err_o
);
   if (ADDR_W < VAL_W) begin : g_bad_addr
      $error("ADDR_W must cover the configuration value");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold a command byte");
   end
   if (PAGE_BIT >= VAL_W) begin : g_bad_bit
      $error("PAGE_BIT outside the register");
   end
   if (MASK_W < 2) begin : g_bad_mask
      $error("MASK_W too small");
   end

   op_e              op;
   rd_mode_e         mode;
   logic             accept;
   logic             clear;
   logic [VAL_W-1:0] held;

   flcfg_decode #(.DATA_W(DATA_W)) u_dec (
      .data_i (data_i),
      .op_o   (op)
   );

   flcfg_seq #(.DATA_W(DATA_W), .VAL_W(VAL_W)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_i),
      .op_i     (op),
      .data_i   (data_i),
      .val_i    (addr_i[VAL_W-1:0]),
      .mode_o   (mode),
      .err_o    (err_o),
      .accept_o (accept),
      .held_o   (held),
      .clear_o  (clear)
   );

   flcfg_store #(.VAL_W(VAL_W), .PAGE_BIT(PAGE_BIT)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_i),
      .accept_i (accept),
      .clear_i  (clear),
      .held_i   (held),
      .page8_o  (page8_o),
      .cfg_o    (cfg_o)
   );

   flcfg_mask #(.MASK_W(MASK_W)) u_mask (
      .mode_i  (mode),
      .page8_i (page8_o),
      .mask_o  (mask_o)
   );

   assign mode_o = mode;
endmodule

// File: rtl/flcfg_check.sv
module flcfg_check #(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int VAL_W    = 16,
   parameter int PAGE_BIT = 13,
   parameter int MASK_W   = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              we_i,
   input logic [DATA_W-1:0] data_i,
   input logic [1:0]        mode_o,
   input logic              page8_o,
   input logic [MASK_W-1:0] mask_o,
   input logic [VAL_W-1:0]  cfg_o,
   input logic              err_o
);
   localparam logic [VAL_W-1:0] LIVE = VAL_W'(1) << PAGE_BIT;

   assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_o & ~LIVE) == '0);

   assert_regmode_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10) |-> (mask_o == '0));

   assert_page_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[PAGE_BIT] == page8_o);

   assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> ($stable(cfg_o) && $stable(mode_o) && $stable(err_o)));

   assert_eight_needs_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(page8_o) |-> ($past(we_i) && ($past(data_i[7:0]) == 8'h50)));

   assert_four_on_confirm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(page8_o) |-> ($past(we_i) && ($past(data_i[7:0]) == 8'h04)));

   assert_err_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> (mode_o == 2'b01));
endmodule

bind flcfg_top flcfg_check #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W),
   .PAGE_BIT(PAGE_BIT), .MASK_W(MASK_W)
) u_check (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .we_i    (we_i),
   .data_i  (data_i),
   .mode_o  (mode_o),
   .page8_o (page8_o),
   .mask_o  (mask_o),
   .cfg_o   (cfg_o),
   .err_o   (err_o)
);

// File: tb/flcfg_top_test.sv
module flcfg_top_test;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        we_i = 1'b0;
   logic [23:0] addr_i = '0;
   logic [7:0]  data_i = '0;
   logic [1:0]  mode_o;
   logic        page8_o;
   logic [2:0]  mask_o;
   logic [15:0] cfg_o;
   logic        err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state, derived from the requirements
   logic [1:0]  m_mode;
   logic        m_page, m_pend, m_err, m_armed;
   logic [15:0] m_held;

   always #5 clk = ~clk;

   flcfg_top uut (
      .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .data_i(data_i),
      .mode_o(mode_o), .page8_o(page8_o), .mask_o(mask_o), .cfg_o(cfg_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_mask();
      if (m_mode == 2'b10) return 3'b000;
      return m_page ? 3'b111 : 3'b011;
   endfunction

   task automatic check_all();
      chk("R2 mode", int'(mode_o), int'(m_mode));
      chk("R4 page8", int'(page8_o), int'(m_page));
      chk("R5 cfg", int'(cfg_o), int'({2'b00, m_page, 13'h0}));
      chk("R8 mask", int'(mask_o), int'(exp_mask()));
      chk("R6 err", int'(err_o), int'(m_err));
   endtask

   task automatic model_reset();
      m_mode = 2'b00; m_page = 0; m_pend = 0; m_err = 0; m_armed = 0; m_held = '0;
   endtask

   task automatic model_write(input logic [23:0] a, input logic [7:0] d);
      if (m_armed) begin
         m_armed = 0;
         if (d == 8'h04 && a[15:0] == m_held) begin
            m_mode = 2'b00;
            if (m_held[13]) m_pend = 1;
            else begin m_page = 0; m_pend = 0; end
         end else begin
            m_mode = 2'b01; m_err = 1; m_pend = 0;
         end
      end else begin
         if (d == 8'h50) begin
            if (m_pend) m_page = 1;
            m_err = 0;
         end
         m_pend = 0;
         case (d)
            8'hFF: m_mode = 2'b00;
            8'h70: m_mode = 2'b01;
            8'h90: m_mode = 2'b10;
            8'h60: begin m_armed = 1; m_held = a[15:0]; end
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [23:0] a, input logic [7:0] d);
      addr_i = a; data_i = d; we_i = 1'b1;
      @(posedge clk);
      #1 we_i = 1'b0;
      model_write(a, d);
      @(negedge clk);
      check_all();
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      model_reset();
      @(negedge clk);
      check_all();           // R1 during reset
      @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      check_all();           // R1 after release
      chk("R1 mask", int'(mask_o), 3);
   endtask

   initial begin
      model_reset();
      do_reset();

      // R2 mode commands, R8 register mode mask
      wr(24'h0, 8'h90); chk("R8 regmask", int'(mask_o), 0);
      wr(24'h0, 8'h70); chk("R2 status", int'(mode_o), 1);
      wr(24'h0, 8'hFF); chk("R2 array", int'(mode_o), 0);

      // R3/R4/R5: eight-word request with junk reserved bits, upper addr differs
      wr(24'h12FFFF, 8'h60);
      wr(24'h34FFFF, 8'h04);
      chk("R3 mode", int'(mode_o), 0);
      chk("R4 pending", int'(page8_o), 0);
      wr(24'hABCDEF, 8'h50);
      chk("R4 eight", int'(page8_o), 1);
      chk("R5 cfg", int'(cfg_o), 16'h2000);
      chk("R8 eightmask", int'(mask_o), 7);

      // R10 back to four words
      wr(24'h0, 8'h60); wr(24'h0, 8'h04);
      chk("R10 four", int'(page8_o), 0);

      // R7 cancelled request
      wr(24'h2000, 8'h60); wr(24'h2000, 8'h04); wr(24'h0, 8'hFF); wr(24'h0, 8'h50);
      chk("R7 dropped", int'(page8_o), 0);

      // R6 mismatched value, then bad confirm byte
      wr(24'h2000, 8'h60); wr(24'h2001, 8'h04);
      chk("R6 err", int'(err_o), 1);
      chk("R6 status", int'(mode_o), 1);
      wr(24'h0, 8'h50); chk("R6 cleared", int'(err_o), 0);
      wr(24'h2000, 8'h60); wr(24'h2000, 8'h10);
      chk("R6 badconf", int'(err_o), 1);
      chk("R6 unchanged", int'(page8_o), 0);

      // R9 idle cycles
      wr(24'h0, 8'h90);
      for (int i = 0; i < 4; i++) begin
         addr_i = 24'h2000; data_i = 8'h50;
         @(negedge clk);
         check_all();
      end

      // R1 reset from eight-word mode
      wr(24'h2000, 8'h60); wr(24'h2000, 8'h04); wr(24'h0, 8'h50);
      chk("R4 eight again", int'(page8_o), 1);
      do_reset();

      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 800; i++) begin
         logic [7:0]  d;
         logic [23:0] a;
         int k;
         k = $urandom_range(0, 9);
         case (k)
            0: d = 8'hFF; 1: d = 8'h70; 2: d = 8'h90;
            3, 4: d = 8'h50; 5, 6: d = 8'h60; 7, 8: d = 8'h04;
            default: d = 8'($urandom);
         endcase
         a = 24'($urandom);
         if ($urandom_range(0, 3) != 0) a[15:0] = m_held;
         if ($urandom_range(0, 1) == 1) a[12:0] = 13'h0;
         wr(a, d);
         if ($urandom_range(0, 7) == 0) begin
            @(negedge clk);
            check_all();     // R9 idle
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule